// File: doc/BRIEF.md
# Nibble-Addressed BCD Calendar Clock

This block keeps the time of day and the calendar as thirteen 4-bit BCD counters: two digits each for seconds, minutes, hours, day of month, month and year, plus a weekday counter. A host reaches them through sixteen nibble-wide registers on a small synchronous bus with a 4-bit address, 4-bit write data, a registered 4-bit read port, and one-cycle read and write strobes. The count is advanced by a single-cycle `tick_i` pulse that stands in for an external one-second source.

Three control registers at the top of the address space govern counting. The host sets a freeze bit to take a consistent snapshot or to load a new time. A tick that arrives during the freeze is remembered and applied once the freeze is lifted. A status bit stays high for a short, fixed window after every count step, so a host that sees it can drop the freeze and retry. Further controls select 12- or 24-hour counting, stop the clock, hold the seconds and the tick state cleared, and round the time to the nearest minute.

Top module: `rtcn_clock`

## Requirements
- R1: After `rst_n` is asserted, the time reads 00:00:00 on day 01, month 01, year 00, weekday 0. Register F reads 4'h4 (24-hour mode, running), and register D reads 0.
- R2: `rdata_o` loads on the clock edge that samples `rd_i` high, and holds its value otherwise. The address map is: 0/1 seconds units/tens, 2/3 minutes, 4/5 hours, 6/7 day, 8/9 month, A/B year units/tens, C weekday, D control, E reserved, F mode. Register E always reads 0 and ignores writes.
- R3: Each applied tick adds one second. The count carries in BCD from 59 seconds into the minutes, from 59 minutes into the hours, and in 24-hour mode from hour 23 to 00 with a carry into the day.
- R4: In 12-hour mode (F bit 2 = 0), hours-tens bits 1:0 hold the tens digit and bit 2 is the PM flag. The hours step 12, 1, …, 11. The PM flag toggles when 11 steps to 12, and the day advances only on the step from 11 PM to 12 AM.
- R5: The day rolls over to 01 after day 30 in months 4, 6, 9 and 11, and after day 31 in the other long months. In month 2 it rolls over after day 29 when the year is a multiple of 4 (00 counts), and after day 28 otherwise. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R6: The weekday (register C, 0 = Sunday) advances at every day rollover and wraps from 6 to 0.
- R7: While D bit 0 (freeze) is 1, the time does not change except through host writes. Any number of ticks during the freeze leave exactly one second pending, and that second is applied on the first cycle after the freeze is released.
- R8: D bit 1 (busy, read-only) reads 1 for BUSY_CYCLES cycles (default 4) after each applied tick, and 0 otherwise.
- R9: While F bit 1 (stop) is 1, ticks are ignored and none are kept pending.
- R10: While F bit 0 (clear) is 1, both seconds digits stay 00, ticks are dropped, and busy is cleared. The other time registers are not affected.
- R11: Writing D bit 3 = 1 requests an adjust, which is carried out on the first cycle the freeze is 0. The adjust sets the seconds to 00 and adds one minute if the seconds were 30 or more. D bit 3 reads 1 while the adjust is waiting and 0 once it has been done.
- R12: Writes to registers 0 to C take effect only while freeze or stop is 1. Otherwise they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, one per second |
| addr_i | input | 4 | Register address |
| wdata_i | input | 4 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 4 | Registered read data |

## Verification
A write or a tick sampled at clock edge N changes the registers at that same edge. A read issued afterwards has its result on `rdata_o` after the next edge. The bench drives every strobe for exactly one cycle between falling edges and samples `rdata_o` on the falling edge that follows the read strobe, so each check sees exactly one register stage. The busy window is checked two cycles after a tick, which falls inside the four-cycle window, and again ten cycles after it, which falls outside. A released freeze applies its pending second on the following edge, and the bench waits at least two cycles before reading the result back.

// File: rtl/rtcn_pkg.sv
package rtcn_pkg;

  localparam int NIB_W       = 4;
  localparam int ADDR_W      = 4;
  localparam int N_TIME_REGS = 13;
  localparam int TIME_W      = NIB_W * N_TIME_REGS;

  localparam logic [ADDR_W-1:0] A_WDAY   = 4'hC;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'hD;
  localparam logic [ADDR_W-1:0] A_RSVD   = 4'hE;
  localparam logic [ADDR_W-1:0] A_MODE   = 4'hF;

  // Packed time image; weekday in the low nibble, then address 0 upward.
  typedef struct packed {
    logic [NIB_W-1:0] yr_t;
    logic [NIB_W-1:0] yr_u;
    logic [NIB_W-1:0] mo_t;
    logic [NIB_W-1:0] mo_u;
    logic [NIB_W-1:0] dy_t;
    logic [NIB_W-1:0] dy_u;
    logic [NIB_W-1:0] hr_t;   // bit 2 = PM flag in 12-hour mode
    logic [NIB_W-1:0] hr_u;
    logic [NIB_W-1:0] mi_t;
    logic [NIB_W-1:0] mi_u;
    logic [NIB_W-1:0] se_t;
    logic [NIB_W-1:0] se_u;
    logic [NIB_W-1:0] wday;
  } rtcn_time_t;

  localparam rtcn_time_t TIME_AT_RESET = rtcn_time_t'(52'h0001010000000);

  function automatic logic [7:0] bcd_val(input logic [3:0] tens, input logic [3:0] units);
    return 8'(tens) * 8'd10 + 8'(units);
  endfunction

  function automatic logic [7:0] to_bcd(input logic [7:0] v);
    return {4'(v / 8'd10), 4'(v % 8'd10)};
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] d;
    case (mon)
      8'd2:                       d = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:    d = 8'd30;
      default:                    d = 8'd31;
    endcase
    return d;
  endfunction

  // Slot of a time register inside the packed image.
  function automatic logic [3:0] time_slot(input logic [ADDR_W-1:0] a);
    return (a == A_WDAY) ? 4'd0 : 4'(a + 4'd1);
  endfunction

endpackage

// File: rtl/rtcn_tick_ctrl.sv
module rtcn_tick_ctrl #(
  parameter int BUSY_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic hold_i,
  input  logic stop_i,
  input  logic clr_i,
  input  logic adj_req_i,
  output logic adv_o,
  output logic adj_go_o,
  output logic busy_o
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic             pend_q, pend_d;
  logic [CNT_W-1:0] bcnt_q, bcnt_d;
  logic             run;

  assign run      = !stop_i && !clr_i;
  assign adj_go_o = adj_req_i && !hold_i;
  assign adv_o    = run && !hold_i && !adj_go_o && (tick_i || pend_q);
  assign busy_o   = (bcnt_q != '0);

  always_comb begin
    if (!run)                  pend_d = 1'b0;
    else if (hold_i || adj_go_o) pend_d = pend_q || tick_i;
    else                       pend_d = pend_q && tick_i;
  end

  always_comb begin
    if (clr_i)               bcnt_d = '0;
    else if (adv_o)          bcnt_d = CNT_W'(BUSY_CYCLES);
    else if (bcnt_q != '0)   bcnt_d = bcnt_q - 1'b1;
    else                     bcnt_d = bcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      bcnt_q <= '0;
    end else begin
      pend_q <= pend_d;
      bcnt_q <= bcnt_d;
    end
  end

endmodule

// File: rtl/rtcn_calendar.sv
module rtcn_calendar
  import rtcn_pkg::*;
(
  input  rtcn_time_t cur_i,
  input  logic       mode24_i,
  input  logic       adv_i,
  input  logic       adj_i,
  output rtcn_time_t nxt_o
);

  logic [7:0] sv, mv, hv, dv, mov, yv, dlen;
  logic       c_min, c_hr, c_day, c_mon, c_yr, pm_n;

  always_comb begin
    nxt_o = cur_i;
    c_min = 1'b0;
    c_hr  = 1'b0;
    c_day = 1'b0;
    c_mon = 1'b0;
    c_yr  = 1'b0;
    pm_n  = cur_i.hr_t[2];
    sv    = bcd_val(cur_i.se_t, cur_i.se_u);
    mv    = bcd_val(cur_i.mi_t, cur_i.mi_u);
    hv    = bcd_val(cur_i.hr_t & 4'b0011, cur_i.hr_u);
    dv    = bcd_val(cur_i.dy_t, cur_i.dy_u);
    mov   = bcd_val(cur_i.mo_t, cur_i.mo_u);
    yv    = bcd_val(cur_i.yr_t, cur_i.yr_u);
    dlen  = month_days(mov, yv);

    // seconds
    if (adj_i) begin
      {nxt_o.se_t, nxt_o.se_u} = 8'h00;
      c_min = (sv >= 8'd30);
    end else if (adv_i) begin
      if (sv >= 8'd59) begin
        {nxt_o.se_t, nxt_o.se_u} = 8'h00;
        c_min = 1'b1;
      end else begin
        {nxt_o.se_t, nxt_o.se_u} = to_bcd(sv + 8'd1);
      end
    end

    // minutes
    if (c_min) begin
      if (mv >= 8'd59) begin
        {nxt_o.mi_t, nxt_o.mi_u} = 8'h00;
        c_hr = 1'b1;
      end else begin
        {nxt_o.mi_t, nxt_o.mi_u} = to_bcd(mv + 8'd1);
      end
    end

    // hours
    if (c_hr) begin
      if (mode24_i) begin
        if (hv >= 8'd23) begin
          {nxt_o.hr_t, nxt_o.hr_u} = 8'h00;
          c_day = 1'b1;
        end else begin
          {nxt_o.hr_t, nxt_o.hr_u} = to_bcd(hv + 8'd1);
        end
      end else begin
        if (hv == 8'd11) begin
          {nxt_o.hr_t, nxt_o.hr_u} = 8'h12;
          pm_n  = !cur_i.hr_t[2];
          c_day = cur_i.hr_t[2];
        end else if (hv >= 8'd12) begin
          {nxt_o.hr_t, nxt_o.hr_u} = 8'h01;
        end else begin
          {nxt_o.hr_t, nxt_o.hr_u} = to_bcd(hv + 8'd1);
        end
        nxt_o.hr_t[2] = pm_n;
      end
    end

    // day and weekday
    if (c_day) begin
      nxt_o.wday = (cur_i.wday >= 4'd6) ? 4'd0 : cur_i.wday + 4'd1;
      if (dv >= dlen) begin
        {nxt_o.dy_t, nxt_o.dy_u} = 8'h01;
        c_mon = 1'b1;
      end else begin
        {nxt_o.dy_t, nxt_o.dy_u} = to_bcd(dv + 8'd1);
      end
    end

    // month
    if (c_mon) begin
      if (mov >= 8'd12) begin
        {nxt_o.mo_t, nxt_o.mo_u} = 8'h01;
        c_yr = 1'b1;
      end else begin
        {nxt_o.mo_t, nxt_o.mo_u} = to_bcd(mov + 8'd1);
      end
    end

    // year
    if (c_yr) begin
      if (yv >= 8'd99) {nxt_o.yr_t, nxt_o.yr_u} = 8'h00;
      else             {nxt_o.yr_t, nxt_o.yr_u} = to_bcd(yv + 8'd1);
    end
  end

endmodule

// File: rtl/rtcn_read_mux.sv
module rtcn_read_mux
  import rtcn_pkg::*;
(
  input  rtcn_time_t        now_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hold_i,
  input  logic              busy_i,
  input  logic              adj_i,
  input  logic              mode24_i,
  input  logic              stop_i,
  input  logic              clr_i,
  output logic [NIB_W-1:0]  nib_o
);

  logic [TIME_W-1:0] flat;
  logic [5:0]        ofs;

  assign flat = now_i;
  assign ofs  = {time_slot(addr_i), 2'b00};

  always_comb begin
    case (addr_i)
      A_CTRL:  nib_o = {adj_i, 1'b0, busy_i, hold_i};
      A_RSVD:  nib_o = '0;
      A_MODE:  nib_o = {1'b0, mode24_i, stop_i, clr_i};
      default: nib_o = flat[ofs +: NIB_W];
    endcase
  end

endmodule

// File: rtl/rtcn_clock.sv
module rtcn_clock
  import rtcn_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NIB_W-1:0]  wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [NIB_W-1:0]  rdata_o
);

  rtcn_time_t        time_q, time_d, cal_nxt;
  logic [TIME_W-1:0] wflat;
  logic [5:0]        wofs;
  logic              hold_q, hold_d, adj_q, adj_d;
  logic              mode24_q, mode24_d, stop_q, stop_d, clr_q, clr_d;
  logic              adv, adj_go, busy;
  logic              time_we, ctl_we, mode_we, time_en;
  logic [NIB_W-1:0]  rd_nib, rdata_q;

  rtcn_tick_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .hold_i    (hold_q),
    .stop_i    (stop_q),
    .clr_i     (clr_q),
    .adj_req_i (adj_q),
    .adv_o     (adv),
    .adj_go_o  (adj_go),
    .busy_o    (busy)
  );

  rtcn_calendar u_cal (
    .cur_i    (time_q),
    .mode24_i (mode24_q),
    .adv_i    (adv),
    .adj_i    (adj_go),
    .nxt_o    (cal_nxt)
  );

  rtcn_read_mux u_rmux (
    .now_i    (time_q),
    .addr_i   (addr_i),
    .hold_i   (hold_q),
    .busy_i   (busy),
    .adj_i    (adj_q),
    .mode24_i (mode24_q),
    .stop_i   (stop_q),
    .clr_i    (clr_q),
    .nib_o    (rd_nib)
  );

  assign time_we = wr_i && (addr_i <= A_WDAY) && (hold_q || stop_q);
  assign ctl_we  = wr_i && (addr_i == A_CTRL);
  assign mode_we = wr_i && (addr_i == A_MODE);
  assign time_en = adv || adj_go || time_we || clr_q;
  assign wofs    = {time_slot(addr_i), 2'b00};

  // time next state: count step, then host write, then clear
  always_comb begin
    wflat  = cal_nxt;
    if (time_we) wflat[wofs +: NIB_W] = wdata_i;
    time_d = rtcn_time_t'(wflat);
    if (clr_q) begin
      time_d.se_u = '0;
      time_d.se_t = '0;
    end
  end

  always_comb begin
    hold_d   = ctl_we  ? wdata_i[0] : hold_q;
    adj_d    = ctl_we  ? wdata_i[3] : (adj_go ? 1'b0 : adj_q);
    mode24_d = mode_we ? wdata_i[2] : mode24_q;
    stop_d   = mode_we ? wdata_i[1] : stop_q;
    clr_d    = mode_we ? wdata_i[0] : clr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= TIME_AT_RESET;
    end else if (time_en) begin
      time_q <= time_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= 1'b0;
      adj_q    <= 1'b0;
      mode24_q <= 1'b1;
      stop_q   <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      hold_q   <= hold_d;
      adj_q    <= adj_d;
      mode24_q <= mode24_d;
      stop_q   <= stop_d;
      clr_q    <= clr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= rd_nib;
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/rtcn_clock_chk.sv
module rtcn_clock_chk
  import rtcn_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input rtcn_time_t        now,
  input logic              hold,
  input logic              stop,
  input logic              clr,
  input logic              adj,
  input logic              adv,
  input logic              busy
);

  // R7: frozen time moves only through host writes
  a_r7_freeze_holds_time: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr && !wr_i) |=> $stable(now));

  // R9: stopped clock ignores ticks
  a_r9_stop_holds_seconds: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !clr && !adj && !wr_i) |=> $stable(now));

  // R8: busy follows every count step
  a_r8_busy_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> busy);

  // R8: busy never rises without a count step
  a_r8_busy_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !adv) |=> !busy);

  // R10: clear keeps seconds at 00
  a_r10_clear_zeroes_seconds: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (now.se_u == 4'd0 && now.se_t == 4'd0));

  // R11: an unfrozen adjust request is consumed in one cycle
  a_r11_adjust_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (adj && !hold && !(wr_i && addr_i == A_CTRL)) |=> !adj);

endmodule

bind rtcn_clock rtcn_clock_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_i   (wr_i),
  .addr_i (addr_i),
  .now    (time_q),
  .hold   (hold_q),
  .stop   (stop_q),
  .clr    (clr_q),
  .adj    (adj_q),
  .adv    (adv),
  .busy   (busy)
);

// File: tb/test_rtcn_clock.sv
module test_rtcn_clock;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 12;

  // nibble a of an image sits at bits [a*4 +: 4], a = 0 (sec units) .. 12 (weekday)
  typedef struct packed {
    logic        m24;
    logic [51:0] start_v;
    logic [51:0] exp_v;
  } vec_t;

  localparam vec_t VECS [N_VEC] = '{
    '{1'b1, 52'h6991231235959, 52'h0000101000000},  // R3 R5 R6 year wrap
    '{1'b1, 52'h3240228235959, 52'h4240229000000},  // R5 leap Feb
    '{1'b1, 52'h2230228235959, 52'h3230301000000},  // R5 common Feb
    '{1'b1, 52'h5210430235959, 52'h6210501000000},  // R5 30-day month
    '{1'b0, 52'h1240615115959, 52'h1240615520000},  // R4 11 AM -> 12 PM
    '{1'b0, 52'h1240615515959, 52'h2240616120000},  // R4 11 PM -> 12 AM, day
    '{1'b0, 52'h1240615525959, 52'h1240615410000},  // R4 12 PM -> 1 PM
    '{1'b1, 52'h1240615101959, 52'h1240615102000},  // R3 minute carry
    '{1'b1, 52'h1240615095959, 52'h1240615100000},  // R3 hour carry
    '{1'b1, 52'h4240229235959, 52'h5240301000000},  // R5 leap day end
    '{1'b1, 52'h6241130235959, 52'h0241201000000},  // R6 weekday wrap
    '{1'b0, 52'h0240101120005, 52'h0240101120006}   // R4 12 AM seconds
  };

  logic       clk, rst_n, tick, wr, rd;
  logic [3:0] addr, wdata, rdata;
  int         n_checks, n_errors;
  bit         done;

  rtcn_clock i_rtcn_clock (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .addr_i  (addr),
    .wdata_i (wdata),
    .wr_i    (wr),
    .rd_i    (rd),
    .rdata_o (rdata)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input string req, input logic [51:0] got, input logic [51:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [3:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic read_all(output logic [51:0] img);
    logic [3:0] n;
    img = '0;
    for (int a = 0; a < 13; a++) begin
      bus_rd(4'(a), n);
      img[a*4 +: 4] = n;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [51:0] img;
    logic [3:0]  n;
    n_checks = 0; n_errors = 0; done = 1'b0;
    tick = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    read_all(img);
    check("R1 time", img, 52'h0000101000000);
    bus_rd(4'hD, n); check("R1 ctrl D", 52'(n), 52'h0);
    bus_rd(4'hF, n); check("R1 mode F", 52'(n), 52'h4);

    // R12 / R2: writes ignored while running, register E reads 0
    bus_wr(4'h0, 4'h5);
    bus_rd(4'h0, n); check("R12 write ignored", 52'(n), 52'h0);
    bus_wr(4'hE, 4'h5);
    bus_rd(4'hE, n); check("R2 reserved reg", 52'(n), 52'h0);

    // table walk: R3 R4 R5 R6
    for (int v = 0; v < N_VEC; v++) begin
      bus_wr(4'hD, 4'h1);
      bus_wr(4'hF, {1'b0, VECS[v].m24, 2'b00});
      for (int a = 0; a < 13; a++) bus_wr(4'(a), VECS[v].start_v[a*4 +: 4]);
      bus_wr(4'hD, 4'h0);
      pulse_tick();
      idle(2);
      read_all(img);
      check($sformatf("R3-6 vector %0d", v), img, VECS[v].exp_v);
    end
    bus_wr(4'hF, 4'h4);

    // R8 busy window
    idle(10);
    pulse_tick();
    bus_rd(4'hD, n); check("R8 busy set", 52'(n[1]), 52'h1);
    idle(10);
    bus_rd(4'hD, n); check("R8 busy clear", 52'(n[1]), 52'h0);

    // R7 freeze with two ticks -> one pending second
    bus_wr(4'hD, 4'h1);
    bus_wr(4'h1, 4'h0);
    bus_wr(4'h0, 4'h3);
    pulse_tick();
    pulse_tick();
    bus_rd(4'h0, n); check("R7 frozen", 52'(n), 52'h3);
    bus_wr(4'hD, 4'h0);
    idle(2);
    bus_rd(4'h0, n); check("R7 pending applied once", 52'(n), 52'h4);

    // R9 stop; R12 writes accepted while stopped
    bus_wr(4'hF, 4'h6);
    pulse_tick();
    bus_rd(4'h0, n); check("R9 stopped", 52'(n), 52'h4);
    bus_wr(4'h0, 4'h7);
    bus_rd(4'h0, n); check("R12 write while stopped", 52'(n), 52'h7);
    bus_wr(4'hF, 4'h4);
    idle(2);
    bus_rd(4'h0, n); check("R9 no tick kept", 52'(n), 52'h7);
    pulse_tick();
    idle(1);
    bus_rd(4'h0, n); check("R9 running again", 52'(n), 52'h8);

    // R10 clear bit
    bus_wr(4'hD, 4'h1);
    bus_wr(4'h1, 4'h4);
    bus_wr(4'h2, 4'h6);
    bus_wr(4'hD, 4'h0);
    bus_wr(4'hF, 4'h5);
    pulse_tick();
    bus_rd(4'h0, n); img[3:0] = n;
    bus_rd(4'h1, n); img[7:4] = n;
    bus_rd(4'h2, n); img[11:8] = n;
    check("R10 clear", {40'h0, img[11:0]}, 52'h600);
    bus_wr(4'hF, 4'h4);
    pulse_tick();
    idle(1);
    bus_rd(4'h0, n); check("R10 released", 52'(n), 52'h1);

    // R11 adjust: 4x seconds -> carry, 1x seconds -> no carry
    bus_wr(4'hD, 4'h1);
    bus_wr(4'h1, 4'h4);
    bus_wr(4'h0, 4'h2);
    bus_wr(4'h3, 4'h1);
    bus_wr(4'h2, 4'h0);
    bus_wr(4'hD, 4'h8);
    idle(1);
    bus_rd(4'h0, n); img[3:0] = n;
    bus_rd(4'h1, n); img[7:4] = n;
    bus_rd(4'h2, n); img[11:8] = n;
    bus_rd(4'h3, n); img[15:12] = n;
    check("R11 carry", {36'h0, img[15:0]}, 52'h1100);
    bus_rd(4'hD, n); check("R11 self clear", 52'(n[3]), 52'h0);
    bus_wr(4'hD, 4'h1);
    bus_wr(4'h1, 4'h1);
    bus_wr(4'hD, 4'h8);
    idle(1);
    bus_rd(4'h1, n); img[3:0] = n;
    bus_rd(4'h2, n); img[7:4] = n;
    check("R11 no carry", {44'h0, img[7:0]}, 52'h10);
    // adjust waits for the freeze to drop
    bus_wr(4'hD, 4'h9);
    bus_wr(4'h1, 4'h5);
    bus_rd(4'hD, n); check("R11 deferred", 52'(n), 52'h9);
    bus_wr(4'hD, 4'h8);
    idle(1);
    bus_rd(4'h1, n); img[3:0] = n;
    bus_rd(4'h2, n); img[7:4] = n;
    check("R11 after release", {44'h0, img[7:0]}, 52'h20);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule